// File: doc/BRIEF.md
# Restart-Mode Entropy Sequencer

This block drives a free-running, gate-based entropy oscillator in restart mode. While it waits, it keeps the oscillator stopped and holds the sampling flops cleared, so every run begins from the same all-zero state. A request starts a new run. The oscillator is enabled for a fixed number of clock cycles. A single-cycle strobe then captures the sampled bit, and the oscillator is stopped and the sampler is cleared again. The captured bit is shown with a valid flag for a fixed presentation window. After that, a settle window must pass before the next restart can begin.

The capture stage is selected by a parameter. In direct mode, a D flop follows the oscillator line while the sampler is released, and its last value is captured. In toggle mode, a flop flips on every low-to-high transition of the oscillator line, and the parity it has reached is captured. The toggle mode gives a better-balanced bit when the raw line has a duty-cycle bias.

All three durations are parameters counted in clock cycles, and one shared down-counter times them. At 50 MHz the defaults give 3 run cycles, 2 presentation cycles and 2 settle cycles, close to a 60/40/40 ns schedule. A run time or settle time below its configured floor stops elaboration. A request that arrives while a run is already in progress is remembered. It starts the next run as soon as the settle window ends.

Top module: `trng_restart_seq`

## Requirements
- R1: During reset and whenever no request is in progress, osc_en_o is 0, smp_rst_o is 1, smp_strobe_o is 0 and bit_valid_o is 0; bit_o resets to 0.
- R2: A request sampled in the idle state drives osc_en_o to 1 from the next cycle. It stays 1 for exactly RUN_CYC consecutive cycles, with smp_rst_o at 0 throughout.
- R3: On the cycle right after the run window, smp_strobe_o is 1 for one cycle and osc_en_o is 0.
- R4: In toggle mode, the bit presented equals the parity of the number of 0-to-1 changes of osc_i seen at the clock edges of the run cycles. The reference level is taken as 0 before the first run cycle.
- R5: In direct mode, the bit presented equals the value of osc_i in the last run cycle.
- R6: bit_valid_o rises on the cycle after the strobe and stays 1 for exactly PRES_CYC cycles. bit_o does not change while bit_valid_o is 1.
- R7: For SETTLE_CYC cycles after bit_valid_o falls, osc_en_o stays 0 and smp_rst_o stays 1.
- R8: A request that arrives during run, sample, present or settle is kept. osc_en_o then rises on the first cycle after the settle window, with no further request needed.
- R9: Each run starts from a cleared sampler: a toggle parity of 1 left by the previous run has no effect on the next bit.
- R10: While requests are kept asserted, successive rises of osc_en_o are exactly RUN_CYC + 1 + PRES_CYC + SETTLE_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request for one random bit, sampled every cycle |
| osc_i | input | 1 | Oscillator output line |
| osc_en_o | output | 1 | Oscillator enable, 1 only during the run window |
| smp_rst_o | output | 1 | Holds the sampling flops in their cleared state |
| smp_strobe_o | output | 1 | One-cycle capture strobe |
| bit_valid_o | output | 1 | Random bit valid, high for the presentation window |
| bit_o | output | 1 | Captured random bit |

## Verification
The bench builds two copies of the block from the same stimulus. One uses toggle capture and the other direct capture, both with RUN_CYC=4, PRES_CYC=2 and SETTLE_CYC=3. That gives a 10-cycle period, long enough to drive multi-edge oscillator patterns within a run. It is also long enough to land requests in the present and settle windows and to check the exact gap before the next restart. The settle length of 3 differs from the presentation length of 2, so swapping the two durations in the design would show up as a wrong gap. A run that leaves the toggle parity at 1 is followed by a run whose expected bit assumes a cleared sampler.

// File: rtl/trng_seq_pkg.sv
package trng_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RUN     = 3'd1,
      ST_SAMPLE  = 3'd2,
      ST_PRESENT = 3'd3,
      ST_SETTLE  = 3'd4
   } seq_state_e;

   typedef enum logic {
      SMP_DIRECT = 1'b0,
      SMP_TOGGLE = 1'b1
   } smp_mode_e;

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/trng_phase_timer.sv
module trng_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

   // R10: every phase begins from the loaded value
   p_load_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));

   // R10: the count steps down by one per cycle until it reaches zero
   p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/trng_bit_sampler.sv
module trng_bit_sampler
   import trng_seq_pkg::*;
#(
   parameter smp_mode_e MODE = SMP_TOGGLE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic osc_i,
   output logic bit_o
);

   generate
      if (MODE == SMP_TOGGLE) begin : g_toggle
         logic prev_q;
         logic tog_q;

         always_ff @(posedge clk) begin
            if (!rst_n || hold_i) begin
               prev_q <= 1'b0;
               tog_q  <= 1'b0;
            end else begin
               prev_q <= osc_i;
               tog_q  <= tog_q ^ (osc_i & ~prev_q);
            end
         end

         assign bit_o = tog_q;

         // R9: a held sampler starts the next run with zero parity
         p_tog_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> (bit_o == 1'b0));
      end else begin : g_direct
         logic d_q;

         always_ff @(posedge clk) begin
            if (!rst_n || hold_i) begin
               d_q <= 1'b0;
            end else begin
               d_q <= osc_i;
            end
         end

         assign bit_o = d_q;

         // R9: the direct flop is cleared while held
         p_dff_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i |=> (bit_o == 1'b0));
      end
   endgenerate

endmodule

// File: rtl/trng_restart_seq.sv
module trng_restart_seq
   import trng_seq_pkg::*;
#(
   parameter int        RUN_CYC        = 3,
   parameter int        PRES_CYC       = 2,
   parameter int        SETTLE_CYC     = 2,
   parameter int        MIN_RUN_CYC    = 2,
   parameter int        MIN_SETTLE_CYC = 2,
   parameter smp_mode_e SAMPLE_MODE    = SMP_TOGGLE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic osc_i,
   output logic osc_en_o,
   output logic smp_rst_o,
   output logic smp_strobe_o,
   output logic bit_valid_o,
   output logic bit_o
);

   localparam int unsigned CNT_MAX = max3(RUN_CYC, PRES_CYC, SETTLE_CYC);
   localparam int          CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] RUN_LD    = CNT_W'(RUN_CYC - 1);
   localparam logic [CNT_W-1:0] PRES_LD   = CNT_W'(PRES_CYC - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
   localparam int          RL_W    = $clog2(RUN_CYC + 2);

   generate
      if (MIN_RUN_CYC < 1) begin : g_bad_min_run
         $error("MIN_RUN_CYC must be at least one cycle");
      end
      if (RUN_CYC < MIN_RUN_CYC) begin : g_run_too_short
         $error("RUN_CYC is below MIN_RUN_CYC");
      end
      if (SETTLE_CYC < MIN_SETTLE_CYC) begin : g_settle_too_short
         $error("SETTLE_CYC is below MIN_SETTLE_CYC");
      end
      if (PRES_CYC < 1) begin : g_bad_pres
         $error("PRES_CYC must be at least one cycle");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic             pend_q, pend_d;
   logic             start;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;
   logic             smp_bit;
   logic             data_q;
   logic             want_run;

   assign want_run = req_i | pend_q;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (want_run) begin
               state_d  = ST_RUN;
               tmr_load = 1'b1;
               tmr_val  = RUN_LD;
            end
         end
         ST_RUN: begin
            if (tmr_done) state_d = ST_SAMPLE;
         end
         ST_SAMPLE: begin
            state_d  = ST_PRESENT;
            tmr_load = 1'b1;
            tmr_val  = PRES_LD;
         end
         ST_PRESENT: begin
            if (tmr_done) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = SETTLE_LD;
            end
         end
         ST_SETTLE: begin
            if (tmr_done) begin
               if (want_run) begin
                  state_d  = ST_RUN;
                  tmr_load = 1'b1;
                  tmr_val  = RUN_LD;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign start  = (state_d == ST_RUN) && (state_q != ST_RUN);
   assign pend_d = start ? 1'b0 : (pend_q | (req_i && state_q != ST_IDLE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   trng_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .done_o     (tmr_done)
   );

   assign osc_en_o     = (state_q == ST_RUN);
   assign smp_rst_o    = !((state_q == ST_RUN) || (state_q == ST_SAMPLE));
   assign smp_strobe_o = (state_q == ST_SAMPLE);
   assign bit_valid_o  = (state_q == ST_PRESENT);

   trng_bit_sampler #(
      .MODE (SAMPLE_MODE)
   ) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (smp_rst_o),
      .osc_i  (osc_i),
      .bit_o  (smp_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= 1'b0;
      end else if (smp_strobe_o) begin
         data_q <= smp_bit;
      end
   end

   assign bit_o = data_q;

   // run-length checker counter
   logic [RL_W-1:0] run_len_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len_q <= '0;
      end else if (osc_en_o) begin
         run_len_q <= run_len_q + 1'b1;
      end else begin
         run_len_q <= '0;
      end
   end

   // R2: the oscillator never runs longer than RUN_CYC cycles
   p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_o |-> (run_len_q < RL_W'(RUN_CYC)));

   // R2: the sampler is released whenever the oscillator runs
   p_run_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_o |-> !smp_rst_o);

   // R3: stopping the oscillator coincides with the capture strobe
   p_strobe_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en_o) |-> smp_strobe_o);

   // R3: the strobe never overlaps a running oscillator
   p_strobe_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe_o |-> !osc_en_o);

   // R6: valid follows the strobe
   p_valid_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe_o |=> bit_valid_o);

   // R6: the presented bit is stable while valid
   p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid_o && $past(bit_valid_o)) |-> $stable(bit_o));

   // R7: while presenting, the oscillator is off and the sampler held
   p_quiet_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid_o |-> (!osc_en_o && smp_rst_o));

endmodule

// File: tb/trng_restart_seq_tb.sv
module trng_restart_seq_tb;
   import trng_seq_pkg::*;

   localparam int RUN    = 4;
   localparam int PRES   = 2;
   localparam int SETTLE = 3;
   localparam int PERIOD = RUN + 1 + PRES + SETTLE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic osc = 1'b0;

   logic en_t, rst_t, stb_t, val_t, bit_t;
   logic en_d, rst_d, stb_d, val_d, bit_d;

   always #10 clk = ~clk;

   trng_restart_seq #(
      .RUN_CYC (RUN), .PRES_CYC (PRES), .SETTLE_CYC (SETTLE),
      .MIN_RUN_CYC (2), .MIN_SETTLE_CYC (2), .SAMPLE_MODE (SMP_TOGGLE)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .req_i (req), .osc_i (osc),
      .osc_en_o (en_t), .smp_rst_o (rst_t), .smp_strobe_o (stb_t),
      .bit_valid_o (val_t), .bit_o (bit_t)
   );

   trng_restart_seq #(
      .RUN_CYC (RUN), .PRES_CYC (PRES), .SETTLE_CYC (SETTLE),
      .MIN_RUN_CYC (2), .MIN_SETTLE_CYC (2), .SAMPLE_MODE (SMP_DIRECT)
   ) u_dut_direct (
      .clk (clk), .rst_n (rst_n), .req_i (req), .osc_i (osc),
      .osc_en_o (en_d), .smp_rst_o (rst_d), .smp_strobe_o (stb_d),
      .bit_valid_o (val_d), .bit_o (bit_d)
   );

   int n_checks = 0;
   int n_fail   = 0;
   logic exp_tog[$];
   logic exp_dir[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- monitor ----------------
   int   cyc = 0;
   int   last_rise = -1;
   int   last_gap = 0;
   logic prev_en = 1'b0;
   logic prev_val = 1'b0;
   int   vlen = 0;
   logic held_t = 1'b0;
   logic held_d = 1'b0;
   int   settle_left = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (en_t && !prev_en) begin
            if (last_rise >= 0) last_gap = cyc - last_rise;
            last_rise = cyc;
         end
         if (val_t && !prev_val) begin
            if (exp_tog.size() == 0 || exp_dir.size() == 0) begin
               chk(1'b0, "R6 unexpected valid", 1, 0);
            end else begin
               logic et, ed;
               et = exp_tog.pop_front();
               ed = exp_dir.pop_front();
               chk(bit_t == et, "R4 toggle bit", bit_t, et);
               chk(bit_d == ed, "R5 direct bit", bit_d, ed);
            end
            chk(val_d == 1'b1, "R6 valid in both modes", val_d, 1);
            vlen   = 1;
            held_t = bit_t;
            held_d = bit_d;
         end else if (val_t) begin
            vlen++;
            chk(bit_t == held_t && bit_d == held_d, "R6 data stable", bit_t, held_t);
         end
         if (!val_t && prev_val) begin
            chk(vlen == PRES, "R6 valid length", vlen, PRES);
            settle_left = SETTLE;
         end
         if (settle_left > 0) begin
            chk(!en_t && rst_t, "R7 settle quiet", en_t, 0);
            settle_left--;
         end
         prev_en  = en_t;
         prev_val = val_t;
      end
   end

   // ---------------- driver ----------------
   task automatic drive_run(input logic [RUN-1:0] pat);
      logic pv, par;
      pv  = 1'b0;
      par = 1'b0;
      for (int k = 0; k < RUN; k++) begin
         if (pat[k] && !pv) par = ~par;
         pv = pat[k];
      end
      exp_tog.push_back(par);
      exp_dir.push_back(pat[RUN-1]);
      while (!en_t) @(negedge clk);
      for (int k = 0; k < RUN; k++) begin
         chk(en_t && !rst_t && en_d, "R2 run window", en_t, 1);
         osc = pat[k];
         @(negedge clk);
      end
      osc = 1'b0;
      chk(stb_t && !en_t && stb_d, "R3 strobe after run", stb_t, 1);
   endtask

   task automatic req_from_idle();
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(en_t == 1'b1, "R2 start latency", en_t, 1);
   endtask

   task automatic wait_idle();
      repeat (PRES + SETTLE + 2) @(negedge clk);
      chk(!en_t && rst_t && !val_t, "R1 back to idle", en_t, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!en_t && rst_t && !stb_t && !val_t && !bit_t, "R1 reset state", en_t, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!en_t && rst_t && !val_t && !en_d, "R1 idle without request", en_t, 0);

      req_from_idle(); drive_run(4'b0000); wait_idle();
      req_from_idle(); drive_run(4'b1111); wait_idle();
      req_from_idle(); drive_run(4'b0101); wait_idle();
      req_from_idle(); drive_run(4'b0110); wait_idle();
      req_from_idle(); drive_run(4'b1001); wait_idle();

      // R9: first run leaves parity 1, next one must start cleared
      req_from_idle(); drive_run(4'b1000); wait_idle();
      req_from_idle(); drive_run(4'b0011); wait_idle();

      // R8: request during present
      req_from_idle(); drive_run(4'b0001);
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      drive_run(4'b1101);
      chk(last_gap == PERIOD, "R8 pending from present", last_gap, PERIOD);

      // R8: request during settle
      repeat (PRES + 1) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      drive_run(4'b0010);
      chk(last_gap == PERIOD, "R8 pending from settle", last_gap, PERIOD);
      wait_idle();

      // R10: continuous requests
      req = 1'b1;
      drive_run(4'b1011);
      drive_run(4'b0100);
      chk(last_gap == PERIOD, "R10 back-to-back period", last_gap, PERIOD);
      req = 1'b0;
      drive_run(4'b1110);
      chk(last_gap == PERIOD, "R10 back-to-back period after drop", last_gap, PERIOD);
      wait_idle();
      repeat (15) @(negedge clk);
      chk(!en_t, "R8 no spurious restart", en_t, 0);
      chk(exp_tog.size() == 0, "R6 all bits presented", exp_tog.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule